// File: doc/BRIEF.md
# Interval Timer Counter Channel

One 16-bit down-counting channel of a programmable interval timer. It is reached through an 8-bit data port, a control-word strobe and a read-back strobe. The host first writes a control word that picks the byte access order, the counting mode and binary or BCD arithmetic. It then writes the count one byte at a time into a holding register. On the next counting tick that value moves into the counting element, which steps down once per tick and drives the `out` waveform.

The host can read the count in two ways. It can read the live count, or it can freeze the count in an output latch with a latch command. A read-back command can also capture an 8-bit status snapshot. A latched status byte is always returned before any count byte. Modes 0, 2 and 3 are fully counted. The remaining mode codes are stored and reported, but they count as mode 0. Choosing among several channels is done by logic outside this block, so the control word arrives without its channel-select bits.

Top module: `pit_channel`

## Requirements
- R1: After reset `out` is 0 and the status byte reads 0x30: access code 11, mode 000, binary, null-count clear, `out` low.
- R2: A control word whose bits 5:4 are not 00 stores access (5:4), mode (3:1) and BCD (0). It returns both byte toggles to the low byte and sets the null-count flag. It forces `out` high for mode codes x10/x11 and low for every other code.
- R3: Count bytes go into the holding register by access code: 01 writes the low byte and clears the high byte, 10 writes the high byte and clears the low byte, 11 writes the low byte then the high byte. The value moves into the counting element on the first `tick` cycle after the final byte is written. That move clears the null-count flag.
- R4: The status byte is {out, null-count, access[1:0], mode[2:0], bcd} from bit 7 down to bit 0.
- R5: A read-back with `rb_sts_n` low captures the status byte, and the next data-port read returns it. If the count is latched as well, the count bytes follow in the programmed order.
- R6: A control word with bits 5:4 equal to 00, or a read-back with `rb_cnt_n` low, freezes the counting element into a latch. The latch is read out until all programmed bytes have been read. Further latch requests are ignored while it holds.
- R7: Mode 0 (and codes 001, 100, 101): `out` goes low at load. It goes high on the tick that takes the count from 1 to 0, and stays high while counting continues.
- R8: Mode x10 (rate): `out` is low for exactly one tick, while the count is 1. The next tick reloads the holding value and raises `out`.
- R9: Mode x11 (square): with even N each phase lasts N/2 ticks. With odd N the high phase lasts (N+1)/2 ticks and the low phase lasts (N-1)/2 ticks, starting high.
- R10: Binary counting wraps from 0x0000 to 0xFFFF. BCD counting steps each decimal digit and wraps from 0000 to 9999.
- R11: The count changes only in cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting enable, one count per high cycle |
| ctl_wr | input | 1 | Control-word strobe |
| ctl_word | input | 6 | Control word: access 5:4, mode 3:1, BCD 0 |
| rb_wr | input | 1 | Read-back command strobe for this channel |
| rb_cnt_n | input | 1 | Read-back: latch count when low |
| rb_sts_n | input | 1 | Read-back: latch status when low |
| port_wr | input | 1 | Data-port write strobe |
| port_wdata | input | 8 | Data-port write byte |
| port_rd | input | 1 | Data-port read strobe, consumes the shown byte |
| port_rdata | output | 8 | Byte the next read returns |
| out | output | 1 | Timer output |

## Verification
Every strobe acts at the clock edge that samples it. A latch or status capture takes the values from before that edge. The count moves into the counting element one edge after the final byte, and `out` reacts at the same edge as the count step that causes it. `port_rdata` is combinational and shows the byte that a read in the current cycle will consume. The monitor therefore compares it half a cycle before the consuming edge. The expected `out` levels are checked after each edge, tick by tick, from the load edge onward. Latch commands are placed at counted edges, so the frozen value is the known count from the previous edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    RW_LATCH = 2'b00,
    RW_LO    = 2'b01,
    RW_HI    = 2'b10,
    RW_BOTH  = 2'b11
  } rw_sel_e;

  typedef struct packed {
    rw_sel_e    rw;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    BEH_ONESHOT = 2'b00,
    BEH_RATE    = 2'b01,
    BEH_SQUARE  = 2'b10
  } beh_e;

  // Mode field decode: bit 2 is don't-care for the x10/x11 codes.
  function automatic beh_e decode_mode(input logic [2:0] m);
    beh_e b;
    if (m[1]) b = m[0] ? BEH_SQUARE : BEH_RATE;
    else      b = BEH_ONESHOT;
    return b;
  endfunction

endpackage

// File: rtl/pit_cfg.sv
module pit_cfg
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [5:0]        ctl_word,
  input  logic              port_wr,
  input  logic [BYTE_W-1:0] port_wdata,
  input  logic              loaded,
  output chan_cfg_t         cfg,
  output logic [CNT_W-1:0]  cr,
  output logic              load_pend,
  output logic              null_cnt,
  output logic              cfg_wr,
  output logic              lat_cmd
);

  chan_cfg_t          cfg_q, cfg_d;
  logic [CNT_W-1:0]   cr_q, cr_d;
  logic               wtog_q, wtog_d;
  logic               pend_q, pend_d;
  logic               null_q, null_d;

  assign cfg_wr  = ctl_wr && (ctl_word[5:4] != 2'b00);
  assign lat_cmd = ctl_wr && (ctl_word[5:4] == 2'b00);

  always_comb begin
    cfg_d  = cfg_q;
    cr_d   = cr_q;
    wtog_d = wtog_q;
    pend_d = pend_q;
    null_d = null_q;
    if (loaded) begin
      pend_d = 1'b0;
      null_d = 1'b0;
    end
    if (cfg_wr) begin
      cfg_d.rw   = rw_sel_e'(ctl_word[5:4]);
      cfg_d.mode = ctl_word[3:1];
      cfg_d.bcd  = ctl_word[0];
      wtog_d     = 1'b0;
      pend_d     = 1'b0;
      null_d     = 1'b1;
    end else if (port_wr) begin
      unique case (cfg_q.rw)
        RW_LO: begin
          cr_d   = {{BYTE_W{1'b0}}, port_wdata};
          pend_d = 1'b1;
          null_d = 1'b1;
        end
        RW_HI: begin
          cr_d   = {port_wdata, {BYTE_W{1'b0}}};
          pend_d = 1'b1;
          null_d = 1'b1;
        end
        RW_BOTH: begin
          if (!wtog_q) begin
            cr_d[BYTE_W-1:0] = port_wdata;
            wtog_d           = 1'b1;
          end else begin
            cr_d[CNT_W-1:BYTE_W] = port_wdata;
            wtog_d               = 1'b0;
            pend_d               = 1'b1;
            null_d               = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{rw: RW_BOTH, mode: 3'b000, bcd: 1'b0};
      cr_q   <= '0;
      wtog_q <= 1'b0;
      pend_q <= 1'b0;
      null_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cr_q   <= cr_d;
      wtog_q <= wtog_d;
      pend_q <= pend_d;
      null_q <= null_d;
    end
  end

  assign cfg       = cfg_q;
  assign cr        = cr_q;
  assign load_pend = pend_q;
  assign null_cnt  = null_q;

  // R2: a control word leaves null-count raised and no load pending
  a_r2_ctl_arms_null: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (null_q && !pend_q));

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DIGITS = CNT_W / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [2:0]       new_mode,
  input  logic [2:0]       mode,
  input  logic             bcd,
  input  logic [CNT_W-1:0] cr,
  input  logic             load_pend,
  output logic [CNT_W-1:0] ce,
  output logic             out,
  output logic             loaded
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                 input logic dec_mode);
    logic [CNT_W-1:0] r;
    logic             borrow;
    if (!dec_mode) begin
      r = v - ONE;
    end else begin
      r      = v;
      borrow = 1'b1;
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[d*4 +: 4] == 4'd0) begin
            r[d*4 +: 4] = 4'd9;
          end else begin
            r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
            borrow      = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  logic [CNT_W-1:0] ce_q, ce_d;
  logic             out_q, out_d;
  logic             run_q, run_d;
  logic             ext_q, ext_d;
  beh_e             beh;
  logic [CNT_W-1:0] dec1, dec2, half_ld;

  assign beh     = decode_mode(mode);
  assign loaded  = tick && load_pend && !cfg_wr;
  assign dec1    = step_down(ce_q, bcd);
  assign dec2    = step_down(dec1, bcd);
  assign half_ld = {cr[CNT_W-1:1], 1'b0};

  always_comb begin
    ce_d  = ce_q;
    out_d = out_q;
    run_d = run_q;
    ext_d = ext_q;
    if (cfg_wr) begin
      run_d = 1'b0;
      ext_d = 1'b0;
      out_d = (decode_mode(new_mode) != BEH_ONESHOT);
    end else if (loaded) begin
      run_d = 1'b1;
      unique case (beh)
        BEH_SQUARE: begin
          ce_d  = half_ld;
          ext_d = cr[0];
          out_d = 1'b1;
        end
        BEH_RATE: begin
          ce_d  = cr;
          out_d = 1'b1;
        end
        default: begin
          ce_d  = cr;
          out_d = 1'b0;
        end
      endcase
    end else if (tick && run_q) begin
      unique case (beh)
        BEH_RATE: begin
          if (ce_q == ONE) begin
            ce_d  = cr;
            out_d = 1'b1;
          end else begin
            ce_d = dec1;
            if (ce_q == TWO) out_d = 1'b0;
          end
        end
        BEH_SQUARE: begin
          if (ce_q == TWO) begin
            if (ext_q) begin
              ext_d = 1'b0;
            end else begin
              out_d = !out_q;
              ce_d  = half_ld;
              ext_d = !out_q && cr[0];
            end
          end else begin
            ce_d = dec2;
          end
        end
        default: begin
          ce_d = dec1;
          if (ce_q == ONE) out_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= '0;
      out_q <= 1'b0;
      run_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      ce_q  <= ce_d;
      out_q <= out_d;
      run_q <= run_d;
      ext_q <= ext_d;
    end
  end

  assign ce  = ce_q;
  assign out = out_q;

  // R3: a load puts the holding value into the counting element
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && beh != BEH_SQUARE) |=> (ce_q == $past(cr)));

  // R7: once high in one-shot behaviour, out holds until reprogrammed or reloaded
  a_r7_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beh == BEH_ONESHOT && out_q && !cfg_wr && !loaded) |=> out_q);

  // R8: the rate generator's low pulse lasts one tick
  a_r8_rate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (beh == BEH_RATE && run_q && !out_q && tick && !cfg_wr && !loaded) |=> out_q);

  // R11: without a tick and without a load the count stands still
  a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_wr) |=> $stable(ce_q));

endmodule

// File: rtl/pit_readout.sv
module pit_readout
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              lat_cmd,
  input  logic              rb_wr,
  input  logic              rb_cnt_n,
  input  logic              rb_sts_n,
  input  logic              port_rd,
  input  rw_sel_e           rw,
  input  logic [CNT_W-1:0]  ce,
  input  logic [7:0]        status,
  output logic [BYTE_W-1:0] rdata
);

  logic              cnt_lat_q, cnt_lat_d;
  logic [CNT_W-1:0]  lat_q, lat_d;
  logic              sts_lat_q, sts_lat_d;
  logic [7:0]        sts_q, sts_d;
  logic              rtog_q, rtog_d;
  logic              cnt_cap, sts_cap, pick_hi;
  logic [CNT_W-1:0]  src;

  assign cnt_cap = (lat_cmd || (rb_wr && !rb_cnt_n)) && !cnt_lat_q;
  assign sts_cap = rb_wr && !rb_sts_n && !sts_lat_q;
  assign src     = cnt_lat_q ? lat_q : ce;
  assign pick_hi = (rw == RW_HI) || ((rw == RW_BOTH) && rtog_q);
  assign rdata   = sts_lat_q ? sts_q[BYTE_W-1:0]
                 : (pick_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);

  always_comb begin
    cnt_lat_d = cnt_lat_q;
    lat_d     = lat_q;
    sts_lat_d = sts_lat_q;
    sts_d     = sts_q;
    rtog_d    = rtog_q;
    if (cfg_wr) begin
      cnt_lat_d = 1'b0;
      sts_lat_d = 1'b0;
      rtog_d    = 1'b0;
    end else begin
      if (port_rd) begin
        if (sts_lat_q) begin
          sts_lat_d = 1'b0;
        end else if (rw == RW_BOTH) begin
          rtog_d = !rtog_q;
          if (rtog_q) cnt_lat_d = 1'b0;
        end else begin
          cnt_lat_d = 1'b0;
        end
      end
      if (cnt_cap) begin
        cnt_lat_d = 1'b1;
        lat_d     = ce;
      end
      if (sts_cap) begin
        sts_lat_d = 1'b1;
        sts_d     = status;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lat_q <= 1'b0;
      lat_q     <= '0;
      sts_lat_q <= 1'b0;
      sts_q     <= '0;
      rtog_q    <= 1'b0;
    end else begin
      cnt_lat_q <= cnt_lat_d;
      lat_q     <= lat_d;
      sts_lat_q <= sts_lat_d;
      sts_q     <= sts_d;
      rtog_q    <= rtog_d;
    end
  end

  // R6: a held latch keeps its value until read out or reprogrammed
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lat_q && !port_rd && !cfg_wr) |=> (cnt_lat_q && $stable(lat_q)));

  // R5: a status read is served first and leaves the count byte order untouched
  a_r5_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_lat_q && port_rd && !cfg_wr) |=> (!sts_lat_q && $stable(rtog_q)));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctl_wr,
  input  logic [5:0]        ctl_word,
  input  logic              rb_wr,
  input  logic              rb_cnt_n,
  input  logic              rb_sts_n,
  input  logic              port_wr,
  input  logic [BYTE_W-1:0] port_wdata,
  input  logic              port_rd,
  output logic [BYTE_W-1:0] port_rdata,
  output logic              out
);

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  chan_cfg_t        cfg;
  logic [CNT_W-1:0] cr, ce;
  logic             load_pend, null_cnt, cfg_wr, lat_cmd, loaded;
  logic [7:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  pit_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctl_wr     (ctl_wr),
    .ctl_word   (ctl_word),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .loaded     (loaded),
    .cfg        (cfg),
    .cr         (cr),
    .load_pend  (load_pend),
    .null_cnt   (null_cnt),
    .cfg_wr     (cfg_wr),
    .lat_cmd    (lat_cmd)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .cfg_wr    (cfg_wr),
    .new_mode  (ctl_word[3:1]),
    .mode      (cfg.mode),
    .bcd       (cfg.bcd),
    .cr        (cr),
    .load_pend (load_pend),
    .ce        (ce),
    .out       (out),
    .loaded    (loaded)
  );

  assign status = {out, null_cnt, cfg.rw, cfg.mode, cfg.bcd};

  pit_readout #(.CNT_W(CNT_W)) u_rdo (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_wr   (cfg_wr),
    .lat_cmd  (lat_cmd),
    .rb_wr    (rb_wr),
    .rb_cnt_n (rb_cnt_n),
    .rb_sts_n (rb_sts_n),
    .port_rd  (port_rd),
    .rw       (cfg.rw),
    .ce       (ce),
    .status   (status),
    .rdata    (port_rdata)
  );

endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       ctl_wr;
  logic [5:0] ctl_word;
  logic       rb_wr, rb_cnt_n, rb_sts_n;
  logic       port_wr;
  logic [7:0] port_wdata;
  logic       port_rd;
  logic [7:0] port_rdata;
  logic       out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = !clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .rb_wr(rb_wr), .rb_cnt_n(rb_cnt_n), .rb_sts_n(rb_sts_n),
    .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rd(port_rd), .port_rdata(port_rdata), .out(out)
  );

  // monitor: compare the byte shown during a read cycle with the queued item
  always @(negedge clk) begin
    if (port_rd) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: got %02h exp none", port_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (port_rdata !== e) begin
          bad++;
          $display("FAIL %s: read got %02h exp %02h", t, port_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl(input logic [5:0] w);
    ctl_wr = 1'b1; ctl_word = w; step(); ctl_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    port_wr = 1'b1; port_wdata = d; step(); port_wr = 1'b0;
  endtask

  task automatic rb(input logic cnt_n, input logic sts_n);
    rb_wr = 1'b1; rb_cnt_n = cnt_n; rb_sts_n = sts_n; step();
    rb_wr = 1'b0; rb_cnt_n = 1'b1; rb_sts_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    port_rd = 1'b1; step(); port_rd = 1'b0;
  endtask

  task automatic chk_out(input logic e, input string t);
    total++;
    if (out !== e) begin
      bad++;
      $display("FAIL %s: out got %0b exp %0b", t, out, e);
    end
  endtask

  task automatic out_seq(input logic [15:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      step();
      chk_out(v[n-1-i], t);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; ctl_wr = 1'b0; ctl_word = '0;
    rb_wr = 1'b0; rb_cnt_n = 1'b1; rb_sts_n = 1'b1;
    port_wr = 1'b0; port_wdata = '0; port_rd = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk_out(1'b0, "R1 reset out");
    rb(1'b1, 1'b0);
    rd(8'h30, "R1 reset status");

    // mode 0 binary, low then high, count 5
    ctl(6'h30);
    chk_out(1'b0, "R2 mode0 out low");
    wr(8'h05); wr(8'h00);
    rb(1'b1, 1'b0);                 // captured in the load edge: null still set
    rd(8'h70, "R4 status null set");
    step(); step(); step();
    chk_out(1'b0, "R7 count 1 out low");
    step();
    chk_out(1'b1, "R7 terminal out high");
    ctl(6'h00);                     // latch count 0
    rd(8'h00, "R3 latched low");
    rd(8'h00, "R3 latched high");
    rb(1'b1, 1'b0);
    rd(8'hB0, "R3 null cleared after load");
    step(); step();
    chk_out(1'b1, "R7 out stays high");

    // mode code 100 acts as mode 0; control word resets write toggle
    ctl(6'h38);
    chk_out(1'b0, "R2 ctl forces out low");
    wr(8'h07);
    ctl(6'h38);
    wr(8'h03); wr(8'h00);
    step();
    chk_out(1'b0, "R7 mode4 out low after load");
    ctl(6'h00);
    rd(8'h03, "R2 toggle reset low byte");
    rd(8'h00, "R2 toggle reset high byte");
    chk_out(1'b1, "R7 mode4 terminal high");

    // R11 tick gating
    ctl(6'h30);
    wr(8'h10); wr(8'h00);
    step();
    tick = 1'b0;
    repeat (4) step();
    ctl(6'h00);
    rd(8'h10, "R11 no tick low");
    rd(8'h00, "R11 no tick high");
    tick = 1'b1;

    // mode code 110 = rate, low byte only
    ctl(6'h1C);
    chk_out(1'b1, "R2 rate out high");
    rb(1'b1, 1'b0);
    rd(8'hDC, "R4 status rate lsb");
    wr(8'h04);
    out_seq(16'b111011101, 9, "R8 rate waveform");

    // mode 3 odd and even
    ctl(6'h36);
    wr(8'h05); wr(8'h00);
    out_seq(16'b1110011100, 10, "R9 square odd");
    ctl(6'h36);
    wr(8'h04); wr(8'h00);
    out_seq(16'b11001, 5, "R9 square even");

    // BCD countdown, latch hold and release
    ctl(6'h31);
    wr(8'h00); wr(8'h01);
    step(); step();
    ctl(6'h00);                     // captures 0099
    repeat (3) step();
    ctl(6'h00);                     // ignored
    rd(8'h99, "R6 held low");
    rd(8'h00, "R6 held high");
    ctl(6'h00);                     // captures 0092
    rd(8'h92, "R10 bcd low");
    rd(8'h00, "R6 relatch high");

    // BCD wrap, status and count latched together
    ctl(6'h31);
    wr(8'h00); wr(8'h00);
    step(); step();
    rb(1'b0, 1'b0);
    rd(8'h31, "R5 status first");
    rd(8'h99, "R10 bcd wrap low");
    rd(8'h99, "R5 count after status");

    // binary wrap
    ctl(6'h30);
    wr(8'h00); wr(8'h00);
    step(); step();
    ctl(6'h00);
    rd(8'hFF, "R10 binary wrap low");
    rd(8'hFF, "R10 binary wrap high");

    // high byte only
    ctl(6'h20);
    wr(8'h12);
    step();
    ctl(6'h00);
    rd(8'h12, "R3 msb only");
    rb(1'b1, 1'b0);
    rd(8'h20, "R4 status msb");
    ctl(6'h00);                     // 0x1200 - 4 = 0x11FC
    rd(8'h11, "R6 single byte release");

    step();
    finish_run();
  end

endmodule